// File: doc/BRIEF.md
# Periodic Wake Sequencer with Wake-Count Limit

This block sequences a radio's timed low-power cycle. The host programs a tick period and a wake limit, then issues a sleep request. The block enters its sleep state and starts a down-counting timer. Each time the timer runs out, the block wakes and adds one to a 16-bit wake tally. Because the period is fixed, the tally tracks elapsed time the way a real-time clock would.

On each wake the block compares the incremented tally with the limit. While the tally is at or below the limit, it reloads the timer and goes back to sleep. Once the tally passes the limit, it requests the off state. A limit of zero gives a single timed sleep.

Two wake causes can raise one sticky interrupt line: every timer wake, and the wake that exceeds the limit. Each cause has its own enable and its own status bit. A clear strobe empties both status bits and the tally.

Top module: `wakeup_tally`

## Requirements
- R1: After reset the block is off (`sleep_o`=0), `count_o`=0, `cause_o`=0 and `irq_o`=0.
- R2: A `sleep_cmd` sampled while off puts the block asleep (`sleep_o`=1) on the next edge. A `sleep_cmd` sampled while asleep has no effect on the timer or on the state.
- R3: The block wakes exactly P clock cycles after sleep entry, and P cycles after each later wake. P is the value of `period_i` captured at sleep entry; changes to `period_i` while asleep have no effect.
- R4: A `period_i` of zero is treated as a period of one cycle.
- R5: Each wake increments `count_o` by one on the same edge. Without a wake or a clear, `count_o` holds.
- R6: On a wake, if the incremented count is less than or equal to `threshold_i`, the block stays asleep; otherwise `sleep_o` falls on that same edge.
- R7: With `threshold_i`=0, the block leaves sleep after exactly one period, whatever count it started from.
- R8: `count_o` saturates at 0xFFFF. With `threshold_i`=0xFFFF the block then never leaves sleep.
- R9: `cause_o[0]` (timeout) is set on every wake while `en_tmo_i`=1. `cause_o[1]` (limit exceeded) is set on the wake that leaves sleep while `en_cnt_i`=1. A disabled cause is never set.
- R10: `irq_o` is the OR of the two cause bits and stays high until a clear.
- R11: `clear_i` zeroes `count_o` and both cause bits on the next edge and wins over a wake in the same cycle. Sleep entry alone does not clear the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sleep_cmd | input | 1 | Request to enter sleep (acted on only while off) |
| period_i | input | 24 | Timer period in clock ticks, captured at sleep entry |
| threshold_i | input | 16 | Wake-count limit |
| en_tmo_i | input | 1 | Enable for the per-wake timeout cause |
| en_cnt_i | input | 1 | Enable for the limit-exceeded cause |
| clear_i | input | 1 | Clears the wake count and cause bits |
| count_o | output | 16 | Wake tally |
| irq_o | output | 1 | Sticky interrupt line |
| cause_o | output | 2 | Cause status: bit 0 timeout, bit 1 limit exceeded |
| sleep_o | output | 1 | Requested state: 1 sleep, 0 off |

## Verification
A vector table pairs periods of zero, one and several cycles with limits from zero to four and all four enable combinations. Measuring the total sleep length separates a wrong period reload from an off-by-one limit compare, and the final cause bits show whether each enable gates only its own cause. Directed runs add three cases. A second sleep request and a period change are injected mid-sleep. A sleep is started from a non-zero count without a clear. Clear is held against period-one wakes and then left running until the count saturates at 0xFFFF.

// File: rtl/wake_pkg.sv
package wake_pkg;
   typedef enum logic {
      ST_OFF   = 1'b0,
      ST_SLEEP = 1'b1
   } wake_state_t;

   localparam int CAUSE_TMO = 0;
   localparam int CAUSE_CNT = 1;
   localparam int N_CAUSE   = 2;
endpackage

// File: rtl/wake_timer.sv
module wake_timer #(
   parameter int PER_W = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic             run_i,
   input  logic [PER_W-1:0] period_i,
   output logic             expire_o
);
   localparam logic [PER_W-1:0] ONE = PER_W'(1);

   generate
      if (PER_W < 2) begin : g_bad_width
         $error("wake_timer: PER_W must be at least 2");
      end
   endgenerate

   logic [PER_W-1:0] period_q, remain_q, period_eff;

   assign period_eff = (period_i == '0) ? ONE : period_i;
   assign expire_o   = run_i && (remain_q == ONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         period_q <= '0;
         remain_q <= '0;
      end else if (load_i) begin
         period_q <= period_eff;
         remain_q <= period_eff;
      end else if (run_i) begin
         if (remain_q == ONE) remain_q <= period_q;
         else                 remain_q <= remain_q - ONE;
      end
   end

   assert_no_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (run_i && !load_i && remain_q > ONE) |=> (remain_q == $past(remain_q) - ONE));

   assert_nonzero_period_R4: assert property (@(posedge clk) disable iff (!rst_n)
      run_i |-> (remain_q != '0));
endmodule

// File: rtl/wake_counter.sv
module wake_counter #(
   parameter int CNT_W    = 16,
   parameter bit SATURATE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear_i,
   input  logic             inc_i,
   input  logic [CNT_W-1:0] limit_i,
   output logic [CNT_W-1:0] count_o,
   output logic             over_o
);
   localparam logic [CNT_W-1:0] MAX = '1;
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   generate
      if (CNT_W < 2 || CNT_W > 32) begin : g_bad_width
         $error("wake_counter: CNT_W out of range");
      end
   endgenerate

   logic [CNT_W-1:0] count_q, count_nxt;

   generate
      if (SATURATE) begin : g_sat
         assign count_nxt = (count_q == MAX) ? MAX : count_q + ONE;
      end else begin : g_wrap
         assign count_nxt = count_q + ONE;
      end
   endgenerate

   assign over_o  = count_nxt > limit_i;
   assign count_o = count_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       count_q <= '0;
      else if (clear_i) count_q <= '0;
      else if (inc_i)   count_q <= count_nxt;
   end

   assert_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (inc_i && !clear_i && count_q != MAX) |=> (count_q == $past(count_q) + ONE));

   assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!inc_i && !clear_i) |=> $stable(count_q));

   assert_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
      clear_i |=> (count_q == '0));

   generate
      if (SATURATE) begin : g_sat_chk
         assert_saturate_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (count_q == MAX && !clear_i) |=> (count_q == MAX));
      end
   endgenerate
endmodule

// File: rtl/wake_cause.sv
module wake_cause #(
   parameter int N = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clear_i,
   input  logic [N-1:0] set_i,
   output logic [N-1:0] cause_o,
   output logic         irq_o
);
   generate
      if (N < 1) begin : g_bad_n
         $error("wake_cause: N must be at least 1");
      end
   endgenerate

   logic [N-1:0] flag_q;

   genvar gi;
   generate
      for (gi = 0; gi < N; gi++) begin : g_flag
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          flag_q[gi] <= 1'b0;
            else if (clear_i)    flag_q[gi] <= 1'b0;
            else if (set_i[gi])  flag_q[gi] <= 1'b1;
         end
      end
   endgenerate

   assign cause_o = flag_q;
   assign irq_o   = |flag_q;

   assert_irq_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_o && !clear_i) |=> irq_o);

   assert_cause_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
      clear_i |=> (flag_q == '0));
endmodule

// File: rtl/wakeup_tally.sv
module wakeup_tally
   import wake_pkg::*;
#(
   parameter int CNT_W    = 16,
   parameter int PER_W    = 24,
   parameter bit SATURATE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sleep_cmd,
   input  logic [PER_W-1:0] period_i,
   input  logic [CNT_W-1:0] threshold_i,
   input  logic             en_tmo_i,
   input  logic             en_cnt_i,
   input  logic             clear_i,
   output logic [CNT_W-1:0] count_o,
   output logic             irq_o,
   output logic [1:0]       cause_o,
   output logic             sleep_o
);
   wake_state_t state_q;
   logic start, run, expire, wake_evt, over;
   logic [N_CAUSE-1:0] cause_set;

   assign start    = (state_q == ST_OFF) && sleep_cmd;
   assign run      = (state_q == ST_SLEEP);
   assign wake_evt = run && expire;

   always_comb begin
      cause_set            = '0;
      cause_set[CAUSE_TMO] = wake_evt && en_tmo_i;
      cause_set[CAUSE_CNT] = wake_evt && over && en_cnt_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                state_q <= ST_OFF;
      else if (start)            state_q <= ST_SLEEP;
      else if (wake_evt && over) state_q <= ST_OFF;
   end

   wake_timer #(.PER_W(PER_W)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_i   (start),
      .run_i    (run),
      .period_i (period_i),
      .expire_o (expire)
   );

   wake_counter #(.CNT_W(CNT_W), .SATURATE(SATURATE)) u_count (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear_i (clear_i),
      .inc_i   (wake_evt),
      .limit_i (threshold_i),
      .count_o (count_o),
      .over_o  (over)
   );

   wake_cause #(.N(N_CAUSE)) u_cause (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear_i (clear_i),
      .set_i   (cause_set),
      .cause_o (cause_o),
      .irq_o   (irq_o)
   );

   assign sleep_o = run;

   assert_enter_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_OFF && sleep_cmd) |=> (state_q == ST_SLEEP));

   assert_leave_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (wake_evt && !clear_i) |=> ((state_q == ST_OFF) == (count_o > $past(threshold_i))));

   assert_stay_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !expire) |=> (state_q == ST_SLEEP));

   assert_tmo_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!clear_i && !cause_o[CAUSE_TMO] && !(wake_evt && en_tmo_i)) |=> !cause_o[CAUSE_TMO]);
endmodule

// File: tb/sim_wakeup_tally.sv
module sim_wakeup_tally;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sleep_cmd = 1'b0;
   logic [23:0] period_i = '0;
   logic [15:0] threshold_i = '0;
   logic        en_tmo_i = 1'b0;
   logic        en_cnt_i = 1'b0;
   logic        clear_i = 1'b0;
   logic [15:0] count_o;
   logic        irq_o;
   logic [1:0]  cause_o;
   logic        sleep_o;

   int checks = 0;
   int fails  = 0;
   int cyc_total = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   wakeup_tally u0 (
      .clk(clk), .rst_n(rst_n), .sleep_cmd(sleep_cmd), .period_i(period_i),
      .threshold_i(threshold_i), .en_tmo_i(en_tmo_i), .en_cnt_i(en_cnt_i),
      .clear_i(clear_i), .count_o(count_o), .irq_o(irq_o), .cause_o(cause_o),
      .sleep_o(sleep_o)
   );

   localparam int NV = 6;
   localparam int VP [NV] = '{3, 1, 0, 5, 2, 7};
   localparam int VT [NV] = '{0, 2, 1, 3, 4, 1};
   localparam int VE [NV] = '{1, 2, 3, 0, 3, 1};

   task automatic report();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
   endtask

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   always @(posedge clk) begin
      cyc_total++;
      if (cyc_total > 190000 && !done) begin
         done = 1'b1;
         fails++;
         checks++;
         $display("FAIL watchdog: actual %0d expected below 190000", cyc_total);
         report();
         $finish;
      end
   end

   task automatic pulse_clear();
      clear_i = 1'b1;
      @(negedge clk);
      clear_i = 1'b0;
   endtask

   task automatic start_sleep();
      sleep_cmd = 1'b1;
      @(negedge clk);
      sleep_cmd = 1'b0;
   endtask

   task automatic run_until_off(output int cyc);
      cyc = 0;
      while (sleep_o && cyc < 5000) begin
         @(negedge clk);
         cyc++;
      end
   endtask

   initial begin
      int cyc;
      int p;
      int expc;
      repeat (3) @(negedge clk);
      // R1: reset state
      check(sleep_o == 1'b0, "R1 sleep", sleep_o, 0);
      check(count_o == 16'd0, "R1 count", count_o, 0);
      check(cause_o == 2'b00 && irq_o == 1'b0, "R1 irq", {cause_o, irq_o}, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // Vector table: R3 R4 R6 R7 R9 R10
      for (int i = 0; i < NV; i++) begin
         pulse_clear();
         period_i    = 24'(VP[i]);
         threshold_i = 16'(VT[i]);
         en_tmo_i    = VE[i][0];
         en_cnt_i    = VE[i][1];
         start_sleep();
         check(sleep_o == 1'b1, "R2 entry", sleep_o, 1);
         run_until_off(cyc);
         p = (VP[i] == 0) ? 1 : VP[i];
         expc = p * (VT[i] + 1);
         check(cyc == expc, "R3 R4 R6 sleep length", cyc, expc);
         check(count_o == 16'(VT[i] + 1), "R5 count", count_o, VT[i] + 1);
         check(cause_o == 2'(VE[i]), "R9 causes", cause_o, VE[i]);
         check(irq_o == (VE[i] != 0), "R10 irq", irq_o, int'(VE[i] != 0));
      end

      // R2/R3: second sleep request and period change during sleep are ignored
      pulse_clear();
      period_i = 24'd4; threshold_i = 16'd1; en_tmo_i = 1'b0; en_cnt_i = 1'b0;
      start_sleep();
      cyc = 0;
      while (sleep_o && cyc < 5000) begin
         if (cyc == 2) begin sleep_cmd = 1'b1; period_i = 24'd20; end
         else sleep_cmd = 1'b0;
         @(negedge clk);
         cyc++;
      end
      sleep_cmd = 1'b0;
      check(cyc == 8, "R2 R3 ignored mid-sleep inputs", cyc, 8);
      check(count_o == 16'd2, "R5 count after mid-sleep inputs", count_o, 2);

      // R11: sleep entry does not clear count
      period_i = 24'd1; threshold_i = 16'd5;
      start_sleep();
      run_until_off(cyc);
      check(count_o == 16'd6, "R11 count kept across entry", count_o, 6);
      check(cyc == 4, "R11 wakes from kept count", cyc, 4);

      // R7: zero threshold from non-zero count
      period_i = 24'd3; threshold_i = 16'd0; en_cnt_i = 1'b1;
      start_sleep();
      run_until_off(cyc);
      check(cyc == 3, "R7 single period", cyc, 3);
      check(count_o == 16'd7, "R7 count", count_o, 7);

      // R10: irq sticky until clear
      repeat (5) @(negedge clk);
      check(irq_o == 1'b1, "R10 irq held", irq_o, 1);
      pulse_clear();
      check(irq_o == 1'b0 && cause_o == 2'b00, "R11 causes cleared", {cause_o, irq_o}, 0);
      check(count_o == 16'd0, "R11 count cleared", count_o, 0);

      // R11 clear beats wake; R4 zero period; R8 saturation
      period_i = 24'd0; threshold_i = 16'hFFFF; en_tmo_i = 1'b1; en_cnt_i = 1'b0;
      clear_i = 1'b1;
      start_sleep();
      repeat (3) @(negedge clk);
      check(count_o == 16'd0, "R11 clear over wake", count_o, 0);
      check(cause_o == 2'b00, "R11 cause clear over wake", cause_o, 0);
      clear_i = 1'b0;
      @(negedge clk);
      check(count_o == 16'd1, "R4 one-cycle wake", count_o, 1);
      repeat (65540) @(negedge clk);
      check(count_o == 16'hFFFF, "R8 saturated", count_o, 65535);
      check(sleep_o == 1'b1, "R8 stays asleep", sleep_o, 1);
      check(irq_o == 1'b1 && cause_o == 2'b01, "R9 timeout only", cause_o, 1);

      rst_n = 1'b0;
      @(negedge clk);
      check(sleep_o == 1'b0 && count_o == 16'd0, "R1 reset again", count_o, 0);

      done = 1'b1;
      report();
      $finish;
   end
endmodule